// File: doc/BRIEF.md
# Dual Alarm Match Interrupt Unit

This block watches a running time-of-day value and raises interrupts when it reaches either of two programmed alarm times. Each alarm stores four match bytes: seconds, minutes, hours and weekday. When the one-cycle second tick arrives, each alarm compares its bytes against the current time. If every field that takes part in the compare is equal, the alarm's pending flag is set. Setting the top bit of a stored byte removes that field from the compare, so an alarm can repeat every minute, every hour or every day.

Software reaches the unit through a small register window driven by read and write strobes. The window holds the eight alarm bytes, a control byte and a read-only status byte. Two active-low interrupt pins report pending alarms whose enables are set. A routing bit in the control byte chooses between two wirings: both alarms share the first pin, or each alarm has a pin of its own. Any read or write of an alarm's bytes acknowledges that alarm and clears its flag.

The counter that produces the time and the wider bus decode sit outside this block.

Top module: `alarm_match_unit`

## Requirements
- R1: After reset, both interrupt pins are high, the control byte (address 8) reads 0x00, the status byte (address 9) reads 0x00 and every alarm byte reads 0x00.
- R2: Alarm k's bytes sit at addresses 4k+0 (seconds), 4k+1 (minutes), 4k+2 (hours) and 4k+3 (weekday). A write to one of these addresses stores the byte, and a read at the same address returns it.
- R3: An alarm flag is set only on a clock edge where the second tick is high and every unmasked field of that alarm equals the matching current-time byte. No flag sets without a tick.
- R4: A stored alarm byte with bit 7 set is ignored in the compare for that field.
- R5: The hours byte is compared in full, including the 12-hour mode bit (bit 6) and the PM bit (bit 5). An alarm written for 11 PM in 12-hour form (0x71) does not match 11 AM (0x51).
- R6: Status bit 0 holds the alarm 0 flag and status bit 1 holds the alarm 1 flag. A flag is set on a match whether or not its enable is set.
- R7: A read strobe or a write strobe at any of alarm k's four addresses clears flag k on that edge and leaves the other alarm's flag unchanged.
- R8: When an alarm k access and a match of alarm k fall on the same edge, flag k ends set.
- R9: Control bit 0 enables alarm 0 and bit 1 enables alarm 1. A pin is driven low only for an alarm whose flag and enable are both set. Control bits 7:3 read as zero.
- R10: With control bit 2 clear, both alarms drive intN0 and intN1 stays high. With bit 2 set, alarm 0 drives intN0 and alarm 1 drives intN1.
- R11: An asserted pin stays low until the flag behind it is cleared by an access or by reset.
- R12: Writes to the status address are ignored and leave both flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| secTick | input | 1 | One-cycle pulse marking a new second |
| curSec | input | 8 | Current seconds byte |
| curMin | input | 8 | Current minutes byte |
| curHour | input | 8 | Current hours byte (12/24-hour encoding) |
| curDay | input | 8 | Current weekday byte |
| busAddr | input | 4 | Register address |
| busWrEn | input | 1 | Write strobe |
| busRdEn | input | 1 | Read strobe (acknowledge side effect) |
| busWrData | input | 8 | Write data |
| busRdData | output | 8 | Read data for busAddr, combinational |
| intN0 | output | 1 | Active-low interrupt pin 0 |
| intN1 | output | 1 | Active-low interrupt pin 1 |

## Verification
The same edge can carry two opposing events: a second tick whose time matches an alarm, and a bus access to that alarm's bytes, which acknowledges it. The bench clears the flag first. It then raises the tick and a write strobe to one of the alarm's bytes in the same cycle, with the time set so that the alarm matches. It reads the status byte afterwards and expects the flag to be set. Repeating the access alone must then clear the flag, which shows that the previous result came from the ordering of the two events and not from a broken clear path.

// File: rtl/alarm_match_pkg.sv
package alarm_match_pkg;
  localparam int FIELD_W      = 8;
  localparam int FIELDS       = 4;
  localparam int NUM_ALARMS   = 2;
  localparam int FIELD_SEL_W  = $clog2(FIELDS);
  localparam int ALARM_SEL_W  = $clog2(NUM_ALARMS);
  localparam int CTRL_W       = 3;

  // strobes from control to datapath
  typedef struct packed {
    logic                   wrEn;
    logic [ALARM_SEL_W-1:0] alarmSel;
    logic [FIELD_SEL_W-1:0] fieldSel;
    logic [FIELD_W-1:0]     wrData;
  } fieldStrobe_t;
endpackage

// File: rtl/alarm_match_dp.sv
module alarm_match_dp
  import alarm_match_pkg::*;
(
  input  logic                      clk,
  input  logic                      rstN,
  input  fieldStrobe_t              strobe,
  input  logic [FIELDS*FIELD_W-1:0] curTime,
  output logic [FIELD_W-1:0]        rdFieldData,
  output logic [NUM_ALARMS-1:0]     hit
);
  logic [FIELD_W-1:0] fieldReg [NUM_ALARMS][FIELDS];

  for (genvar a = 0; a < NUM_ALARMS; a++) begin : gAlarm
    logic [FIELDS-1:0] fieldOk;
    for (genvar f = 0; f < FIELDS; f++) begin : gField
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)
          fieldReg[a][f] <= '0;
        else if (strobe.wrEn && strobe.alarmSel == ALARM_SEL_W'(a)
                 && strobe.fieldSel == FIELD_SEL_W'(f))
          fieldReg[a][f] <= strobe.wrData;
      end
      // top bit of a stored byte makes the field a don't-care
      assign fieldOk[f] = fieldReg[a][f][FIELD_W-1] ||
                          (fieldReg[a][f] == curTime[f*FIELD_W +: FIELD_W]);
    end
    assign hit[a] = &fieldOk;
  end

  assign rdFieldData = fieldReg[strobe.alarmSel][strobe.fieldSel];
endmodule

// File: rtl/alarm_match_ctrl.sv
module alarm_match_ctrl
  import alarm_match_pkg::*;
#(
  parameter int ADDR_W = 4
)(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  secTick,
  input  logic [ADDR_W-1:0]     busAddr,
  input  logic                  busWrEn,
  input  logic                  busRdEn,
  input  logic [FIELD_W-1:0]    busWrData,
  input  logic [FIELD_W-1:0]    rdFieldData,
  input  logic [NUM_ALARMS-1:0] hit,
  output fieldStrobe_t          strobe,
  output logic [FIELD_W-1:0]    busRdData,
  output logic                  intN0,
  output logic                  intN1
);
  localparam int ALARM_SPAN = NUM_ALARMS * FIELDS;
  localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(ALARM_SPAN);
  localparam logic [ADDR_W-1:0] STAT_ADDR = ADDR_W'(ALARM_SPAN + 1);
  localparam int ROUTE_BIT = NUM_ALARMS;

  logic                   inAlarm;
  logic [ALARM_SEL_W-1:0] alarmIdx;
  logic [NUM_ALARMS-1:0]  accAlarm;
  logic [NUM_ALARMS-1:0]  flags;
  logic [NUM_ALARMS-1:0]  flagsNxt;
  logic [CTRL_W-1:0]      ctrlReg;
  logic [NUM_ALARMS-1:0]  ctrlEn;
  logic                   ctrlRoute;

  assign inAlarm  = busAddr < ADDR_W'(ALARM_SPAN);
  assign alarmIdx = busAddr[FIELD_SEL_W +: ALARM_SEL_W];

  assign strobe.wrEn     = busWrEn && inAlarm;
  assign strobe.alarmSel = alarmIdx;
  assign strobe.fieldSel = busAddr[FIELD_SEL_W-1:0];
  assign strobe.wrData   = busWrData;

  for (genvar a = 0; a < NUM_ALARMS; a++) begin : gAcc
    assign accAlarm[a] = (busWrEn || busRdEn) && inAlarm &&
                         alarmIdx == ALARM_SEL_W'(a);
  end

  // acknowledge first, match last: a same-edge match wins
  always_comb begin
    flagsNxt = flags;
    for (int a = 0; a < NUM_ALARMS; a++) begin
      if (accAlarm[a]) flagsNxt[a] = 1'b0;
      if (secTick && hit[a]) flagsNxt[a] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) flags <= '0;
    else       flags <= flagsNxt;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      ctrlReg <= '0;
    else if (busWrEn && busAddr == CTRL_ADDR)
      ctrlReg <= busWrData[CTRL_W-1:0];
  end

  assign ctrlEn    = ctrlReg[NUM_ALARMS-1:0];
  assign ctrlRoute = ctrlReg[ROUTE_BIT];

  always_comb begin
    if (inAlarm)                     busRdData = rdFieldData;
    else if (busAddr == CTRL_ADDR)   busRdData = FIELD_W'(ctrlReg);
    else if (busAddr == STAT_ADDR)   busRdData = FIELD_W'(flags);
    else                             busRdData = '0;
  end

  logic [NUM_ALARMS-1:0] live;
  assign live  = flags & ctrlEn;
  assign intN0 = !(live[0] || (!ctrlRoute && live[1]));
  assign intN1 = !(ctrlRoute && live[1]);

  AST_NO_SET_WITHOUT_TICK: assert property (@(posedge clk) disable iff (!rstN)
    !secTick |=> ((flags & ~$past(flags)) == '0)); // R3
  AST_SET_WINS_A0: assert property (@(posedge clk) disable iff (!rstN)
    (secTick && hit[0]) |=> flags[0]); // R8
  AST_SET_WINS_A1: assert property (@(posedge clk) disable iff (!rstN)
    (secTick && hit[1]) |=> flags[1]); // R8
  AST_ACCESS_CLEARS_A0: assert property (@(posedge clk) disable iff (!rstN)
    (accAlarm[0] && !(secTick && hit[0])) |=> !flags[0]); // R7
  AST_ACCESS_CLEARS_A1: assert property (@(posedge clk) disable iff (!rstN)
    (accAlarm[1] && !(secTick && hit[1])) |=> !flags[1]); // R7
  AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (flags[0] && !accAlarm[0]) |=> flags[0]); // R11
  AST_PIN1_NEEDS_ROUTE: assert property (@(posedge clk) disable iff (!rstN)
    !intN1 |-> (ctrlRoute && flags[1])); // R10
  AST_PIN0_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    !intN0 |-> (flags != '0)); // R9
endmodule

// File: rtl/alarm_match_unit.sv
module alarm_match_unit
  import alarm_match_pkg::*;
#(
  parameter int ADDR_W = 4
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic              secTick,
  input  logic [7:0]        curSec,
  input  logic [7:0]        curMin,
  input  logic [7:0]        curHour,
  input  logic [7:0]        curDay,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic [7:0]        busWrData,
  output logic [7:0]        busRdData,
  output logic              intN0,
  output logic              intN1
);
  fieldStrobe_t              strobe;
  logic [FIELD_W-1:0]        rdFieldData;
  logic [NUM_ALARMS-1:0]     hit;
  logic [FIELDS*FIELD_W-1:0] curTime;

  assign curTime = {curDay, curHour, curMin, curSec};

  alarm_match_ctrl #(.ADDR_W(ADDR_W)) uCtrl (
    .clk(clk), .rstN(rstN), .secTick(secTick),
    .busAddr(busAddr), .busWrEn(busWrEn), .busRdEn(busRdEn),
    .busWrData(busWrData), .rdFieldData(rdFieldData), .hit(hit),
    .strobe(strobe), .busRdData(busRdData), .intN0(intN0), .intN1(intN1)
  );

  alarm_match_dp uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .curTime(curTime),
    .rdFieldData(rdFieldData), .hit(hit)
  );
endmodule

// File: tb/alarm_match_unit_test.sv
module alarm_match_unit_test;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       secTick = 1'b0;
  logic [7:0] curSec = '0, curMin = '0, curHour = '0, curDay = '0;
  logic [3:0] busAddr = '0;
  logic       busWrEn = 1'b0, busRdEn = 1'b0;
  logic [7:0] busWrData = '0;
  logic [7:0] busRdData;
  logic       intN0, intN1;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  typedef struct {
    string      tag;
    bit         isPins;
    logic [7:0] exp;
  } item_t;
  item_t scoreQ[$];

  alarm_match_unit uut (
    .clk(clk), .rstN(rstN), .secTick(secTick),
    .curSec(curSec), .curMin(curMin), .curHour(curHour), .curDay(curDay),
    .busAddr(busAddr), .busWrEn(busWrEn), .busRdEn(busRdEn),
    .busWrData(busWrData), .busRdData(busRdData),
    .intN0(intN0), .intN1(intN1)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // monitor: samples a quarter period after the falling edge
  always begin
    @(negedge clk);
    #(CLK_PERIOD/4);
    if (scoreQ.size() > 0) begin
      item_t it;
      logic [7:0] act;
      it  = scoreQ.pop_front();
      act = it.isPins ? {6'b0, intN1, intN0} : busRdData;
      checks++;
      if (act !== it.exp) begin
        failures++;
        $display("FAIL %s actual=%02h expected=%02h", it.tag, act, it.exp);
      end
    end
  end

  task automatic expectReg(input string tag, input logic [3:0] addr, input logic [7:0] exp);
    item_t it;
    @(negedge clk);
    busAddr = addr;
    it.tag = tag; it.isPins = 1'b0; it.exp = exp;
    scoreQ.push_back(it);
    wait (scoreQ.size() == 0);
  endtask

  task automatic expectPins(input string tag, input logic [1:0] exp);
    item_t it;
    @(negedge clk);
    it.tag = tag; it.isPins = 1'b1; it.exp = {6'b0, exp};
    scoreQ.push_back(it);
    wait (scoreQ.size() == 0);
  endtask

  task automatic busWrite(input logic [3:0] addr, input logic [7:0] data);
    @(negedge clk);
    busAddr = addr; busWrData = data; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic busRead(input logic [3:0] addr);
    @(negedge clk);
    busAddr = addr; busRdEn = 1'b1;
    @(negedge clk);
    busRdEn = 1'b0;
  endtask

  task automatic setTime(input logic [7:0] s, m, h, d);
    @(negedge clk);
    curSec = s; curMin = m; curHour = h; curDay = d;
  endtask

  task automatic tick();
    @(negedge clk);
    secTick = 1'b1;
    @(negedge clk);
    secTick = 1'b0;
  endtask

  task automatic tickWithWrite(input logic [3:0] addr, input logic [7:0] data);
    @(negedge clk);
    secTick = 1'b1; busAddr = addr; busWrData = data; busWrEn = 1'b1;
    @(negedge clk);
    secTick = 1'b0; busWrEn = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    expectPins("R1 pins", 2'b11);
    expectReg("R1 control", 4'd8, 8'h00);
    expectReg("R1 status", 4'd9, 8'h00);
    expectReg("R1 alarm byte", 4'd5, 8'h00);

    // R2 program alarm 0 = 09:15:30 any day, alarm 1 = weekday 3 only
    busWrite(4'd0, 8'h30); busWrite(4'd1, 8'h15);
    busWrite(4'd2, 8'h09); busWrite(4'd3, 8'h80);
    busWrite(4'd4, 8'h80); busWrite(4'd5, 8'h80);
    busWrite(4'd6, 8'h80); busWrite(4'd7, 8'h03);
    expectReg("R2 a0 seconds", 4'd0, 8'h30);
    expectReg("R2 a0 hours", 4'd2, 8'h09);
    expectReg("R2 a1 weekday", 4'd7, 8'h03);
    expectReg("R7 reads without strobe keep status", 4'd9, 8'h00);

    // R3 no match one second early
    setTime(8'h29, 8'h15, 8'h09, 8'h02);
    tick();
    expectReg("R3 no match", 4'd9, 8'h00);
    // R3 match values present but no tick
    setTime(8'h30, 8'h15, 8'h09, 8'h02);
    expectReg("R3 no tick", 4'd9, 8'h00);
    // R4 weekday masked, R6 flag sets with enable clear
    tick();
    expectReg("R4 R6 alarm0 flag", 4'd9, 8'h01);
    expectPins("R9 disabled pin high", 2'b11);

    // R9 enable alarm 0
    busWrite(4'd8, 8'h01);
    expectPins("R9 intN0 low", 2'b10);
    repeat (5) @(negedge clk);
    expectPins("R11 stays low", 2'b10);

    // R7 read strobe acknowledges
    busRead(4'd2);
    expectReg("R7 read clears", 4'd9, 8'h00);
    expectPins("R11 released", 2'b11);

    // alarm 1 on weekday 3 only
    setTime(8'h00, 8'h00, 8'h10, 8'h03);
    tick();
    expectReg("R6 alarm1 flag", 4'd9, 8'h02);
    expectPins("R9 alarm1 not enabled", 2'b11);
    busWrite(4'd8, 8'h02);
    expectPins("R10 shared pin", 2'b10);
    busWrite(4'd8, 8'h06);
    expectPins("R10 split pin", 2'b01);

    // R7 other alarm's access leaves flag
    busWrite(4'd0, 8'h30);
    expectReg("R7 other alarm kept", 4'd9, 8'h02);
    busWrite(4'd7, 8'h03);
    expectReg("R7 write clears", 4'd9, 8'h00);

    // R5 12-hour PM encoding, alarm 0 hours only
    busWrite(4'd0, 8'h80); busWrite(4'd1, 8'h80); busWrite(4'd2, 8'h71);
    setTime(8'h00, 8'h00, 8'h51, 8'h01);
    tick();
    expectReg("R5 AM does not match PM", 4'd9, 8'h00);
    setTime(8'h00, 8'h00, 8'h71, 8'h01);
    tick();
    expectReg("R5 PM match", 4'd9, 8'h01);

    // R12 status write ignored
    busWrite(4'd9, 8'h00);
    expectReg("R12 flag kept", 4'd9, 8'h01);
    busRead(4'd0);
    busWrite(4'd9, 8'h03);
    expectReg("R12 nothing set", 4'd9, 8'h00);

    // R8 access and match on the same edge
    tickWithWrite(4'd1, 8'h80);
    expectReg("R8 set wins", 4'd9, 8'h01);
    busWrite(4'd1, 8'h80);
    expectReg("R8 plain access clears", 4'd9, 8'h00);

    // R9 control readback
    busWrite(4'd8, 8'hFF);
    expectReg("R9 control bits", 4'd8, 8'h07);

    finished = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule